// File: doc/BRIEF.md
# Flash Reset and Power-Mode Controller

This block is the control logic of a parallel NOR-style flash device that sits between the external control pins and the inner machinery: the command state machine, the embedded program/erase engine and the output drivers. It qualifies the active-low hardware reset pin, sends a one-cycle abort to the command state machine, and holds reads and writes off until the internal reset and the post-release delay are complete. The recovery time depends on whether a program or erase was running when the reset was qualified. While a running operation is being aborted, the ready/busy pin stays low.

Two low-power states are reported as mode flags. Chip-deselect standby switches off the output drivers whatever the output-enable level, but it never starts while the embedded engine is busy. Auto-sleep starts after the address has been stable for a set number of cycles, whatever the state of the control pins. In auto-sleep the last output data is held. An address change ends sleep at once and restarts the normal address access time. All delays are counted in clock cycles and set by parameters.

Top module: `flash_pm_ctrl`

## Requirements
- R1: The reset pin qualifies on the clock edge that completes T_RP consecutive sampled-low cycles. `csm_abort` is high for exactly the one cycle after that edge, and `mode_reset` rises at the same time.
- R2: A low pulse on the reset pin that lasts fewer than T_RP cycles has no effect: no abort, no `mode_reset`, and `read_ok` and `dout_en` are unchanged.
- R3: While the qualified reset is in progress (`mode_reset` = 1), `dout_en`, `read_ok` and `write_ok` are all 0, whatever the levels of `ce_n`, `oe_n` and `we_n`.
- R4: If `engine_busy` is 1 at the qualifying edge, `ready_busy` stays 0 for T_READY_EMB cycles from that edge and returns to 1 on the T_READY_EMB-th edge after it.
- R5: If `engine_busy` is 0 at the qualifying edge, `ready_busy` stays 1 and the internal reset takes T_READY_IDLE cycles. `engine_busy` is sampled on the qualifying edge itself.
- R6: `mode_reset` stays high until both of these hold: the internal reset time has run out, and T_RH cycles have passed since the pin returned high. `read_ok` then rises T_CE cycles after `mode_reset` falls.
- R7: With `ce_n` = 1 and no reset or engine activity, `mode_standby` = 1 and `dout_en` = 0 even when `oe_n` = 0.
- R8: After `ce_n` falls, `read_ok` stays 0 for T_CE edges and becomes 1 after the T_CE-th edge.
- R9: While `engine_busy` = 1 the mode is busy (`mode_busy` = 1, `mode_standby` = 0) even with `ce_n` = 1. Standby begins as soon as `engine_busy` drops.
- R10: `dout_hold` rises after T_SLEEP consecutive edges with an unchanged address, whether or not `ce_n`, `oe_n` and `we_n` toggle. While it is high the output data stays latched.
- R11: Any address change clears `dout_hold` and `mode_sleep` in the same cycle. `read_ok` is then 0 until T_ACC edges have passed with a stable address.
- R12: At most one mode flag is high, with priority from highest to lowest: reset, busy, standby, sleep. Active is the state when none of the flags is set.
- R13: Outside a reset, `ready_busy` equals the inverse of `engine_busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| sys_rst_n | input | 1 | Power-on reset of the control registers, active low |
| rst_pin_n | input | 1 | Hardware reset pin, active low, filtered |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Address bus |
| engine_busy | input | 1 | Program/erase engine running |
| ready_busy | output | 1 | Ready/busy pin level (1 = ready) |
| dout_en | output | 1 | Data output driver enable (0 = high impedance) |
| write_ok | output | 1 | Write attempt accepted |
| csm_abort | output | 1 | One-cycle abort to the command state machine |
| read_ok | output | 1 | Read data valid and permitted |
| dout_hold | output | 1 | Output data latched by auto-sleep |
| mode_reset | output | 1 | Reset in progress |
| mode_busy | output | 1 | Program/erase active |
| mode_standby | output | 1 | Deselect standby |
| mode_sleep | output | 1 | Auto-sleep |

## Verification
Two events can land on the same edge: the qualification of a reset and the falling edge of `engine_busy`. Which of the two recovery times applies depends on the level that edge samples. The bench runs the race both ways. In one run `engine_busy` drops in the cycle before the qualifying edge, and the bench expects the short recovery with `ready_busy` high. In the other run `engine_busy` stays high through that edge, and the bench expects `ready_busy` to be held low for the full embedded window. In both runs the bench also times the rise of `read_ok` to the exact edge.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [2:0] {
        MODE_ACTIVE,
        MODE_SLEEP,
        MODE_STANDBY,
        MODE_BUSY,
        MODE_RESET
    } fpm_mode_e;

endpackage

// File: rtl/fpm_reset_seq.sv
module fpm_reset_seq #(
    parameter int T_RP         = 4,
    parameter int T_READY_EMB  = 16,
    parameter int T_READY_IDLE = 5,
    parameter int T_RH         = 3
) (
    input  logic clk,
    input  logic sys_rst_n,
    input  logic pin_n,
    input  logic engine_busy,
    output logic abort_o,
    output logic in_rst_o,
    output logic emb_hold_o
);

    localparam int LO_W    = $clog2(T_RP + 1);
    localparam int REC_MAX = (T_READY_EMB > T_READY_IDLE) ? T_READY_EMB : T_READY_IDLE;
    localparam int REC_W   = $clog2(REC_MAX + 1);
    localparam int RH_W    = $clog2(T_RH + 1);

    typedef struct packed {
        logic [LO_W-1:0]  lo;
        logic             held;
        logic             abort;
        logic [REC_W-1:0] rec;
        logic             emb;
        logic [RH_W-1:0]  rh;
    } rst_state_t;

    rst_state_t st_d, st_q;
    logic       pin_low;
    logic       qual;

    always_comb begin
        st_d    = st_q;
        pin_low = !pin_n;
        qual    = pin_low && (st_q.lo == LO_W'(T_RP - 1)) && !st_q.held;

        // consecutive-low counter, saturating at the qualification point
        if (!pin_low) begin
            st_d.lo = '0;
        end else if (st_q.lo != LO_W'(T_RP - 1)) begin
            st_d.lo = st_q.lo + 1'b1;
        end

        st_d.abort = qual;

        if (qual) begin
            st_d.held = 1'b1;
        end else if (!pin_low) begin
            st_d.held = 1'b0;
        end

        // internal reset duration picked by engine activity at qualification
        if (qual) begin
            st_d.rec = engine_busy ? REC_W'(T_READY_EMB) : REC_W'(T_READY_IDLE);
        end else if (st_q.rec != '0) begin
            st_d.rec = st_q.rec - 1'b1;
        end

        if (qual) begin
            st_d.emb = engine_busy;
        end else begin
            st_d.emb = st_q.emb && (st_d.rec != '0);
        end

        // post-release delay
        if (st_q.held && !pin_low) begin
            st_d.rh = RH_W'(T_RH);
        end else if (st_q.rh != '0) begin
            st_d.rh = st_q.rh - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign abort_o    = st_q.abort;
    assign in_rst_o   = st_q.held || (st_q.rec != '0) || (st_q.rh != '0);
    assign emb_hold_o = st_q.emb;

    a_r1_abort_needs_low_pin: assert property (@(posedge clk) disable iff (!sys_rst_n)
        abort_o |-> $past(!pin_n));

    a_r6_release_keeps_reset: assert property (@(posedge clk) disable iff (!sys_rst_n)
        ($past(st_q.held) && $past(pin_n)) |-> in_rst_o);

endmodule

// File: rtl/fpm_access_timer.sv
module fpm_access_timer #(
    parameter int AW      = 8,
    parameter int T_CE    = 3,
    parameter int T_ACC   = 2,
    parameter int T_SLEEP = 8
) (
    input  logic          clk,
    input  logic          sys_rst_n,
    input  logic [AW-1:0] addr,
    input  logic          ce_n,
    input  logic          in_rst,
    output logic          acc_done_o,
    output logic          sleep_o
);

    localparam int ACC_MAX = (T_CE > T_ACC) ? T_CE : T_ACC;
    localparam int ACC_W   = $clog2(ACC_MAX + 1);
    localparam int STB_W   = $clog2(T_SLEEP + 1);

    typedef struct packed {
        logic [AW-1:0]    addr;
        logic [ACC_W-1:0] acc;
        logic [STB_W-1:0] stab;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic       addr_chg;

    always_comb begin
        st_d      = st_q;
        addr_chg  = (addr != st_q.addr);
        st_d.addr = addr;

        // access countdown: chip-enable time after deselect or reset, address time on change
        if (ce_n || in_rst) begin
            st_d.acc = ACC_W'(T_CE);
        end else if (addr_chg) begin
            st_d.acc = ACC_W'(T_ACC);
        end else if (st_q.acc != '0) begin
            st_d.acc = st_q.acc - 1'b1;
        end

        // address stability counter, blind to the control pins
        if (addr_chg) begin
            st_d.stab = '0;
        end else if (st_q.stab != STB_W'(T_SLEEP)) begin
            st_d.stab = st_q.stab + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            st_q.addr <= '0;
            st_q.acc  <= ACC_W'(T_CE);
            st_q.stab <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_done_o = (st_q.acc == '0) && !addr_chg;
    assign sleep_o    = (st_q.stab == STB_W'(T_SLEEP)) && !addr_chg;

    a_r10_sleep_on_stable_addr: assert property (@(posedge clk) disable iff (!sys_rst_n)
        sleep_o |-> ($past(addr) == addr));

    a_r8_no_read_on_select: assert property (@(posedge clk) disable iff (!sys_rst_n)
        ($past(ce_n) && !ce_n) |-> !acc_done_o);

endmodule

// File: rtl/flash_pm_ctrl.sv
module flash_pm_ctrl
    import fpm_pkg::*;
#(
    parameter int AW           = 8,
    parameter int T_RP         = 4,
    parameter int T_READY_EMB  = 16,
    parameter int T_READY_IDLE = 5,
    parameter int T_RH         = 3,
    parameter int T_CE         = 3,
    parameter int T_ACC        = 2,
    parameter int T_SLEEP      = 8
) (
    input  logic          clk,
    input  logic          sys_rst_n,
    input  logic          rst_pin_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic          engine_busy,
    output logic          ready_busy,
    output logic          dout_en,
    output logic          write_ok,
    output logic          csm_abort,
    output logic          read_ok,
    output logic          dout_hold,
    output logic          mode_reset,
    output logic          mode_busy,
    output logic          mode_standby,
    output logic          mode_sleep
);

    logic      in_rst;
    logic      emb_hold;
    logic      acc_done;
    logic      sleep_raw;
    fpm_mode_e mode_d;

    fpm_reset_seq #(
        .T_RP        (T_RP),
        .T_READY_EMB (T_READY_EMB),
        .T_READY_IDLE(T_READY_IDLE),
        .T_RH        (T_RH)
    ) i_reset_seq (
        .clk        (clk),
        .sys_rst_n  (sys_rst_n),
        .pin_n      (rst_pin_n),
        .engine_busy(engine_busy),
        .abort_o    (csm_abort),
        .in_rst_o   (in_rst),
        .emb_hold_o (emb_hold)
    );

    fpm_access_timer #(
        .AW     (AW),
        .T_CE   (T_CE),
        .T_ACC  (T_ACC),
        .T_SLEEP(T_SLEEP)
    ) i_access_timer (
        .clk       (clk),
        .sys_rst_n (sys_rst_n),
        .addr      (addr),
        .ce_n      (ce_n),
        .in_rst    (in_rst),
        .acc_done_o(acc_done),
        .sleep_o   (sleep_raw)
    );

    always_comb begin
        if (in_rst) begin
            mode_d = MODE_RESET;
        end else if (engine_busy) begin
            mode_d = MODE_BUSY;
        end else if (ce_n) begin
            mode_d = MODE_STANDBY;
        end else if (sleep_raw) begin
            mode_d = MODE_SLEEP;
        end else begin
            mode_d = MODE_ACTIVE;
        end
    end

    assign mode_reset   = (mode_d == MODE_RESET);
    assign mode_busy    = (mode_d == MODE_BUSY);
    assign mode_standby = (mode_d == MODE_STANDBY);
    assign mode_sleep   = (mode_d == MODE_SLEEP);

    assign ready_busy = emb_hold ? 1'b0 : (in_rst ? 1'b1 : !engine_busy);
    assign dout_en    = !in_rst && !ce_n && !oe_n;
    assign write_ok   = !in_rst && !ce_n && !we_n;
    assign read_ok    = !in_rst && !ce_n && acc_done;
    assign dout_hold  = sleep_raw;

    a_r1_abort_single: assert property (@(posedge clk) disable iff (!sys_rst_n)
        csm_abort |=> !csm_abort);

    a_r1_abort_enters_reset: assert property (@(posedge clk) disable iff (!sys_rst_n)
        csm_abort |-> mode_reset);

    a_r4_busy_abort_holds_pin: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (csm_abort && $past(engine_busy)) |-> !ready_busy);

    a_r5_idle_abort_ready: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (csm_abort && !$past(engine_busy)) |-> ready_busy);

    a_r6_no_read_after_reset: assert property (@(posedge clk) disable iff (!sys_rst_n)
        read_ok |-> !$past(mode_reset));

    a_r7_standby_hiz: assert property (@(posedge clk) disable iff (!sys_rst_n)
        mode_standby |-> !dout_en);

    a_r12_one_mode: assert property (@(posedge clk) disable iff (!sys_rst_n)
        $onehot0({mode_reset, mode_busy, mode_standby, mode_sleep}));

endmodule

// File: tb/test_flash_pm_ctrl.sv
module test_flash_pm_ctrl;

    logic       clk = 1'b0;
    logic       sys_rst_n = 1'b0;
    logic       rst_pin_n = 1'b1;
    logic       ce_n = 1'b1;
    logic       oe_n = 1'b0;
    logic       we_n = 1'b1;
    logic [7:0] addr = 8'h00;
    logic       engine_busy = 1'b0;
    logic ready_busy, dout_en, write_ok, csm_abort, read_ok, dout_hold;
    logic mode_reset, mode_busy, mode_standby, mode_sleep;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    flash_pm_ctrl i_flash_pm_ctrl (
        .clk(clk), .sys_rst_n(sys_rst_n), .rst_pin_n(rst_pin_n), .ce_n(ce_n),
        .oe_n(oe_n), .we_n(we_n), .addr(addr), .engine_busy(engine_busy),
        .ready_busy(ready_busy), .dout_en(dout_en), .write_ok(write_ok),
        .csm_abort(csm_abort), .read_ok(read_ok), .dout_hold(dout_hold),
        .mode_reset(mode_reset), .mode_busy(mode_busy),
        .mode_standby(mode_standby), .mode_sleep(mode_sleep)
    );

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk("R12 reset state standby", mode_standby, 1'b1);
        chk("R7 reset state dout off", dout_en, 1'b0);
        chk("R13 reset state ready", ready_busy, 1'b1);
        chk("R1 reset state no abort", csm_abort, 1'b0);
        ce_n = 1'b0;
        tick(12);
        chk("R8 settled read", read_ok, 1'b1);
        chk("R10 settled sleep", mode_sleep, 1'b1);
    endtask

    task automatic t_short_pulse();
        rst_pin_n = 1'b0;
        tick(3);
        chk("R2 short pulse no abort", csm_abort, 1'b0);
        chk("R2 short pulse no reset", mode_reset, 1'b0);
        rst_pin_n = 1'b1;
        tick(1);
        chk("R2 after pulse no abort", csm_abort, 1'b0);
        chk("R2 after pulse read kept", read_ok, 1'b1);
        chk("R2 after pulse dout kept", dout_en, 1'b1);
    endtask

    task automatic t_reset_idle();
        we_n = 1'b0;
        rst_pin_n = 1'b0;
        tick(3);
        chk("R1 not yet qualified", mode_reset, 1'b0);
        tick(1);
        chk("R1 abort pulse", csm_abort, 1'b1);
        chk("R1 reset mode", mode_reset, 1'b1);
        chk("R3 dout off in reset", dout_en, 1'b0);
        chk("R3 write refused", write_ok, 1'b0);
        chk("R3 read refused", read_ok, 1'b0);
        chk("R5 idle ready high", ready_busy, 1'b1);
        rst_pin_n = 1'b1;
        we_n = 1'b1;
        tick(1);
        chk("R1 abort single", csm_abort, 1'b0);
        tick(3);
        chk("R6 reset held by idle time", mode_reset, 1'b1);
        tick(1);
        chk("R5 idle reset done", mode_reset, 1'b0);
        tick(2);
        chk("R6 read waits access", read_ok, 1'b0);
        tick(1);
        chk("R6 read permitted", read_ok, 1'b1);
    endtask

    task automatic t_reset_embedded();
        engine_busy = 1'b1;
        tick(1);
        chk("R13 busy pin low", ready_busy, 1'b0);
        chk("R9 busy mode", mode_busy, 1'b1);
        rst_pin_n = 1'b0;
        tick(4);
        chk("R1 abort during program", csm_abort, 1'b1);
        chk("R12 reset over busy", mode_busy, 1'b0);
        engine_busy = 1'b0;
        tick(2);
        rst_pin_n = 1'b1;
        tick(13);
        chk("R4 pin held busy", ready_busy, 1'b0);
        chk("R3 no read in embedded recovery", read_ok, 1'b0);
        tick(1);
        chk("R4 pin ready at window end", ready_busy, 1'b1);
        tick(2);
        chk("R6 read waits access", read_ok, 1'b0);
        tick(1);
        chk("R6 read after embedded", read_ok, 1'b1);
    endtask

    task automatic t_race_busy_drop();
        engine_busy = 1'b1;
        rst_pin_n = 1'b0;
        tick(3);
        engine_busy = 1'b0;
        tick(1);
        chk("R5 race abort", csm_abort, 1'b1);
        chk("R5 race picks idle", ready_busy, 1'b1);
        rst_pin_n = 1'b1;
        tick(7);
        chk("R5 race read waits", read_ok, 1'b0);
        tick(1);
        chk("R5 race idle timing", read_ok, 1'b1);
    endtask

    task automatic t_standby();
        ce_n = 1'b1;
        oe_n = 1'b0;
        tick(1);
        chk("R7 standby mode", mode_standby, 1'b1);
        chk("R7 standby dout off", dout_en, 1'b0);
        chk("R7 standby no read", read_ok, 1'b0);
        ce_n = 1'b0;
        tick(2);
        chk("R8 access not yet", read_ok, 1'b0);
        tick(1);
        chk("R8 access done", read_ok, 1'b1);
    endtask

    task automatic t_deselect_busy();
        engine_busy = 1'b1;
        ce_n = 1'b1;
        tick(1);
        chk("R9 busy not standby", mode_standby, 1'b0);
        chk("R9 busy mode", mode_busy, 1'b1);
        engine_busy = 1'b0;
        #1;
        chk("R9 standby after busy", mode_standby, 1'b1);
        chk("R13 ready after busy", ready_busy, 1'b1);
        tick(1);
        ce_n = 1'b0;
        tick(3);
    endtask

    task automatic t_sleep();
        addr = 8'h5a;
        #1;
        chk("R11 sleep left at once", mode_sleep, 1'b0);
        chk("R11 hold cleared", dout_hold, 1'b0);
        chk("R11 read dropped", read_ok, 1'b0);
        tick(1);
        oe_n = 1'b1; we_n = 1'b0;
        chk("R11 address access", read_ok, 1'b0);
        tick(1);
        oe_n = 1'b0; we_n = 1'b1;
        chk("R11 address access 2", read_ok, 1'b0);
        tick(1);
        oe_n = 1'b1; we_n = 1'b0;
        chk("R11 address access done", read_ok, 1'b1);
        tick(5);
        oe_n = 1'b0; we_n = 1'b1;
        chk("R10 not yet asleep", dout_hold, 1'b0);
        tick(1);
        chk("R10 asleep", mode_sleep, 1'b1);
        chk("R10 data latched", dout_hold, 1'b1);
        chk("R10 latched data readable", read_ok, 1'b1);
        ce_n = 1'b1;
        #1;
        chk("R10 hold ignores ce", dout_hold, 1'b1);
        chk("R12 standby over sleep", mode_sleep, 1'b0);
        tick(1);
        ce_n = 1'b0;
    endtask

    initial begin
        tick(3);
        sys_rst_n = 1'b1;
        tick(1);
        t_reset_state();
        t_short_pulse();
        t_reset_idle();
        tick(2);
        t_reset_embedded();
        tick(2);
        t_race_busy_drop();
        tick(2);
        t_standby();
        t_deselect_busy();
        t_sleep();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule